// File: doc/BRIEF.md
# Line-Addressed Read Port Controller

This block runs the read side of a video field store that is organised as 290 lines of 768 words. Each word is 12 bits. A line address is clocked in one bit at a time. It is kept in a stored-line register, and it also loads the working line counter. A word pointer then walks along the selected line. The block presents the current (line, word) address to a memory array, which is modelled as a combinational read port. It registers the word read from that address onto the data output.

A single clock with the command input high replaces a long address sequence. Two control inputs pick one of four actions:
- keep the line and restart it at word 0;
- return to line 0, word 0;
- step to the next line;
- jump back to the stored line.

The read-enable input decides whether the pointer advances and whether a new word is captured. The output-enable input only gates the output drivers, and the pointer keeps moving while the outputs float.

Top module: `line_read_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, lineAddr and wordAddr are 0, dataOut is 0, readValid is 0 and the stored line is 0.
- R2: With addrEn high and cmdReq low, addrBit is shifted in most significant bit first, one bit per clock. On the clock of the 9th bit, the 9-bit value is written to the stored line and to lineAddr, and wordAddr becomes 0. If addrEn drops or cmdReq rises before the 9th bit, the partial value is discarded and the next load starts from its first bit.
- R3: With cmdReq high, {lineStep, addrEn} selects the command. 2'b00 keeps lineAddr and sets wordAddr to 0. 2'b01 sets both lineAddr and wordAddr to 0. 2'b10 adds one to lineAddr and sets wordAddr to 0. 2'b11 loads lineAddr from the stored line and sets wordAddr to 0.
- R4: Command 2'b01 does not alter the stored line, so a later command 2'b11 returns to the last loaded line.
- R5: Command 2'b10 issued on line 289 gives line 0.
- R6: On a clock with rdEn high and neither cmdReq nor addrEn high, dataOut takes the array word at the current (lineAddr, wordAddr), and wordAddr advances by one.
- R7: On a clock with rdEn low and neither cmdReq nor addrEn high, wordAddr and dataOut keep their values.
- R8: dataDrive, the output driver enable, follows outEn. With outEn low, the pointer still advances on rdEn.
- R9: Once wordAddr reaches 767, further reads keep it at 767 and keep returning word 767.
- R10: readValid is high in the cycle after a clock with rdEn and outEn both high and neither cmdReq nor addrEn high. Otherwise it is low.
- R11: On a clock with cmdReq or addrEn high, no word is captured: dataOut is unchanged and wordAddr does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read enable: advance pointer and capture word |
| outEn | input | 1 | Output enable for the data drivers |
| cmdReq | input | 1 | Marks a one-clock address command |
| lineStep | input | 1 | Command select bit (upper) |
| addrEn | input | 1 | Serial address enable / command select bit (lower) |
| addrBit | input | 1 | Serial line address, MSB first |
| memData | input | 12 | Word returned by the array for the current address |
| lineAddr | output | 9 | Current line to the array |
| wordAddr | output | 10 | Current word to the array |
| dataOut | output | 12 | Registered read word |
| dataDrive | output | 1 | Output driver enable (high drives dataOut) |
| readValid | output | 1 | dataOut holds a word delivered this cycle |

## Verification
The two functions that can meet in one clock are a line command or address load, and a read request: rdEn and outEn can stay high while cmdReq or addrEn is high. The vector table holds rdEn and outEn high across the whole serial load and across every command. After each such clock it checks three things: the command took effect, wordAddr is 0, and readValid is low. The next plain read must then return word 0 of the new line. A long run of reads pushes the pointer into saturation at the end of the line, and a command issued on line 289 checks that the line steps back to 0.

// File: rtl/lrp_pkg.sv
package lrp_pkg;
  localparam int LINE_W_DEF  = 9;
  localparam int WORD_W_DEF  = 10;
  localparam int DATA_W_DEF  = 12;
  localparam int LINES_DEF   = 290;
  localparam int WORDS_DEF   = 768;

  // command codes on {lineStep, addrEn} while cmdReq is high
  typedef enum logic [1:0] {
    CMD_HOLD   = 2'b00,
    CMD_ORIGIN = 2'b01,
    CMD_STEP   = 2'b10,
    CMD_JUMP   = 2'b11
  } lrpCmd_e;

  typedef struct packed {
    logic loadLine;   // serial address complete
    logic holdLine;   // keep line, word to 0
    logic clrLine;    // line and word to 0
    logic incLine;    // next line, word to 0
    logic jumpLine;   // stored line, word to 0
    logic accessRd;   // plain cycle with read enable
    logic accessShow; // plain cycle with read and output enable
  } lrpStrobe_t;
endpackage

// File: rtl/lrp_ctrl.sv
module lrp_ctrl
  import lrp_pkg::*;
#(
  parameter int LINE_W = LINE_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              outEn,
  input  logic              cmdReq,
  input  logic              lineStep,
  input  logic              addrEn,
  input  logic              addrBit,
  output lrpStrobe_t        strb,
  output logic [LINE_W-1:0] shiftVal
);
  localparam int CNT_W = $clog2(LINE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(LINE_W - 1);

  logic [LINE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  shiftCnt;
  logic              setCyc;
  logic              lastBit;
  lrpCmd_e           cmd;

  assign setCyc   = addrEn && !cmdReq;
  assign lastBit  = setCyc && (shiftCnt == LAST_BIT);
  assign shiftVal = {shiftReg[LINE_W-2:0], addrBit};
  assign cmd      = lrpCmd_e'({lineStep, addrEn});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      shiftCnt <= '0;
    end else if (setCyc) begin
      shiftReg <= shiftVal;
      shiftCnt <= lastBit ? '0 : shiftCnt + 1'b1;
    end else begin
      shiftCnt <= '0;
    end
  end

  always_comb begin
    strb            = '0;
    strb.loadLine   = lastBit;
    strb.accessRd   = !cmdReq && !addrEn && rdEn;
    strb.accessShow = !cmdReq && !addrEn && rdEn && outEn;
    if (cmdReq) begin
      case (cmd)
        CMD_HOLD:   strb.holdLine = 1'b1;
        CMD_ORIGIN: strb.clrLine  = 1'b1;
        CMD_STEP:   strb.incLine  = 1'b1;
        default:    strb.jumpLine = 1'b1;
      endcase
    end
  end

  // R2: a completed load happens only in an address-set cycle
  p_load_in_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLine |-> (addrEn && !cmdReq));

  // R3: at most one line action per clock
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadLine, strb.holdLine, strb.clrLine, strb.incLine, strb.jumpLine}));
endmodule

// File: rtl/lrp_dpath.sv
module lrp_dpath
  import lrp_pkg::*;
#(
  parameter int LINE_W = LINE_W_DEF,
  parameter int WORD_W = WORD_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int LINES  = LINES_DEF,
  parameter int WORDS  = WORDS_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  lrpStrobe_t        strb,
  input  logic [LINE_W-1:0] shiftVal,
  input  logic [DATA_W-1:0] memData,
  output logic [LINE_W-1:0] lineCnt,
  output logic [WORD_W-1:0] wordPtr,
  output logic [DATA_W-1:0] dataReg,
  output logic              validReg
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

  logic [LINE_W-1:0] storedLine;
  logic [LINE_W-1:0] nextLine;
  logic              restartWord;

  assign restartWord = strb.loadLine | strb.holdLine | strb.clrLine |
                       strb.incLine  | strb.jumpLine;

  always_comb begin
    nextLine = lineCnt;
    if (strb.loadLine)      nextLine = shiftVal;
    else if (strb.clrLine)  nextLine = '0;
    else if (strb.incLine)  nextLine = (lineCnt == LAST_LINE) ? '0 : lineCnt + 1'b1;
    else if (strb.jumpLine) nextLine = storedLine;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedLine <= '0;
      lineCnt    <= '0;
      wordPtr    <= '0;
      dataReg    <= '0;
      validReg   <= 1'b0;
    end else begin
      lineCnt  <= nextLine;
      validReg <= strb.accessShow;
      if (strb.loadLine) storedLine <= shiftVal;
      if (restartWord) begin
        wordPtr <= '0;
      end else if (strb.accessRd) begin
        dataReg <= memData;
        if (wordPtr != LAST_WORD) wordPtr <= wordPtr + 1'b1;
      end
    end
  end

  // R9: pointer stays at the last word of the line
  p_word_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accessRd && wordPtr == LAST_WORD) |=> wordPtr == LAST_WORD);

  // R4: going to the origin leaves the stored line alone
  p_origin_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrLine |=> $stable(storedLine));

  // R5: stepping past the last line gives line 0
  p_line_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incLine && lineCnt == LAST_LINE) |=> lineCnt == '0);

  // R2: a completed load sets stored line and counter, word at 0
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLine |=> (storedLine == $past(shiftVal)) && (lineCnt == storedLine) && (wordPtr == '0));
endmodule

// File: rtl/line_read_port.sv
module line_read_port
  import lrp_pkg::*;
#(
  parameter int LINE_W = LINE_W_DEF,
  parameter int WORD_W = WORD_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int LINES  = LINES_DEF,
  parameter int WORDS  = WORDS_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              outEn,
  input  logic              cmdReq,
  input  logic              lineStep,
  input  logic              addrEn,
  input  logic              addrBit,
  input  logic [DATA_W-1:0] memData,
  output logic [LINE_W-1:0] lineAddr,
  output logic [WORD_W-1:0] wordAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive,
  output logic              readValid
);
  lrpStrobe_t        strb;
  logic [LINE_W-1:0] shiftVal;

  lrp_ctrl #(.LINE_W(LINE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .outEn(outEn),
    .cmdReq(cmdReq), .lineStep(lineStep), .addrEn(addrEn), .addrBit(addrBit),
    .strb(strb), .shiftVal(shiftVal)
  );

  lrp_dpath #(
    .LINE_W(LINE_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
    .LINES(LINES), .WORDS(WORDS)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .shiftVal(shiftVal), .memData(memData),
    .lineCnt(lineAddr), .wordPtr(wordAddr), .dataReg(dataOut), .validReg(readValid)
  );

  assign dataDrive = outEn;

  // R11: no capture during command or address-set clocks
  p_cmd_no_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq || addrEn) |=> $stable(dataOut) && !readValid);

  // R7: read enable low freezes pointer and data
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReq && !addrEn && !rdEn) |=> $stable(wordAddr) && $stable(dataOut));

  // R10: valid only after a plain clock with both enables
  p_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> $past(rdEn && outEn && !cmdReq && !addrEn));
endmodule

// File: tb/line_read_port_tb_top.sv
module line_read_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, outEn = 1'b0, cmdReq = 1'b0, lineStep = 1'b0;
  logic        addrEn = 1'b0, addrBit = 1'b0;
  logic [11:0] memData;
  logic [8:0]  lineAddr;
  logic [9:0]  wordAddr;
  logic [11:0] dataOut;
  logic        dataDrive, readValid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  // array model: a known word per (line, word)
  function automatic logic [11:0] memf(input logic [8:0] ln, input logic [9:0] wd);
    return {ln[5:0], wd[5:0]} ^ 12'hA5C;
  endfunction
  assign memData = memf(lineAddr, wordAddr);

  line_read_port dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .outEn(outEn), .cmdReq(cmdReq),
    .lineStep(lineStep), .addrEn(addrEn), .addrBit(addrBit), .memData(memData),
    .lineAddr(lineAddr), .wordAddr(wordAddr), .dataOut(dataOut),
    .dataDrive(dataDrive), .readValid(readValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic a, input logic b,
                       input logic r, input logic o);
    cmdReq = c; lineStep = s; addrEn = a; addrBit = b; rdEn = r; outEn = o;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadLine(input logic [8:0] v);
    for (int i = 8; i >= 0; i--) begin
      drive(1'b0, 1'b0, 1'b1, v[i], 1'b1, 1'b1);
      tick();
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  typedef struct packed {
    logic       c, s, a, b, r, o;
    logic [8:0] ln;
    logic [9:0] wd;
    logic       v;
  } vec_t;

  localparam int NV = 19;
  // load line 5 with both enables high, then reads and every command
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 9'd5, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 9'd5, 10'd1, 1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 9'd5, 10'd2, 1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 9'd5, 10'd2, 1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 9'd5, 10'd3, 1'b0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 9'd6, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 9'd6, 10'd1, 1'b1},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 9'd0, 10'd0, 1'b0},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 9'd5, 10'd0, 1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 9'd5, 10'd1, 1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 9'd5, 10'd0, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 line in reset", 32'(lineAddr), 32'd0);
    chk("R1 data in reset", 32'(dataOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", 32'(wordAddr), 32'd0);
    chk("R1 valid after reset", 32'(readValid), 32'd0);

    // table: R2 R3 R4 R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].c, VECS[i].s, VECS[i].a, VECS[i].b, VECS[i].r, VECS[i].o);
      tick();
      chk($sformatf("R3 vec%0d line", i), 32'(lineAddr), 32'(VECS[i].ln));
      chk($sformatf("R6 vec%0d word", i), 32'(wordAddr), 32'(VECS[i].wd));
      chk($sformatf("R10 vec%0d valid", i), 32'(readValid), 32'(VECS[i].v));
    end
    // R11: last word captured before the command was word 0 of line 5
    chk("R11 data held over command", 32'(dataOut), 32'(memf(9'd5, 10'd0)));

    // R6 and R7: read one word, then hold
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); tick();
    chk("R6 data word0", 32'(dataOut), 32'(memf(9'd5, 10'd0)));
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); tick(); tick();
    chk("R7 data held", 32'(dataOut), 32'(memf(9'd5, 10'd0)));
    chk("R7 word held", 32'(wordAddr), 32'd1);

    // R8: outputs released, pointer still moves
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    #0.5;
    chk("R8 drive low", 32'(dataDrive), 32'd0);
    tick();
    chk("R8 word advances", 32'(wordAddr), 32'd2);
    chk("R8 data captured", 32'(dataOut), 32'(memf(9'd5, 10'd1)));
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    #0.5;
    chk("R8 drive high", 32'(dataDrive), 32'd1);

    // R5: step past line 289
    loadLine(9'd289);
    chk("R2 load 289", 32'(lineAddr), 32'd289);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); tick();
    chk("R5 wrap to 0", 32'(lineAddr), 32'd0);
    chk("R5 word 0", 32'(wordAddr), 32'd0);

    // R2: partial load discarded
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); tick();
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); tick();
    chk("R2 partial ignored", 32'(lineAddr), 32'd0);
    loadLine(9'd3);
    chk("R2 fresh load", 32'(lineAddr), 32'd3);

    // R4: origin then jump returns to line 3
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); tick();
    chk("R4 origin", 32'(lineAddr), 32'd0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); tick();
    chk("R4 jump back", 32'(lineAddr), 32'd3);

    // R9: run to the end of the line
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 770; i++) tick();
    chk("R9 word saturates", 32'(wordAddr), 32'd767);
    chk("R9 last word repeats", 32'(dataOut), 32'(memf(9'd3, 10'd767)));
    chk("R10 valid while reading", 32'(readValid), 32'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule